// File: doc/BRIEF.md
# Clock output power-down sequencer

This block controls entry into and exit from a low-power state for a bank of differential clock outputs. A forwarded clock arrives as a plain signal. The block samples it with a faster reference clock and forwards it to every enabled output pair as a true level and a complement level, each with its own output-enable (tri-state) control. An asynchronous active-low request turns the power-saving state on and off. The block also drives the enable of an upstream PLL and reads back its lock indication.

Entry into power-down is qualified. The request is synchronised first. It must then be seen low on two consecutive complement-clock rising edges. After that, every pair stops on the next complement-clock falling edge, so the last pulse keeps its full width. The PLL enable is dropped only after all pairs are parked. The parked pattern is set by a drive-mode input: either the true output held high with the complement tri-stated, or both tri-stated.

On exit, the PLL is enabled and the outputs stay parked until lock is reported. They then restart only during a low phase of the true clock, so the first high pulse is full width. Two limits are counted in reference cycles while waiting for lock. One raises a lock-timeout flag. The other, in the tri-state mode, starts driving the pairs again.

Top module: `clkout_pd_seq`

## Requirements
- R1: While `rst` is high, `pll_en` is 0, `lock_timeout` is 0, and every pair shows the parked pattern for the current `tri_mode`.
- R2: `pwr_req_n` passes through a two-flop synchroniser. A low pulse short enough to be seen on only one complement-clock rising edge (a falling edge of the sampled forwarded clock) does not power the outputs down.
- R3: Power-down begins only after the synchronised request is low on two consecutive complement-clock rising edges. The pairs then park on the next complement-clock falling edge (a rising edge of the true output), and no true-output high pulse is shorter than half a forwarded-clock period.
- R4: With `tri_mode` = 0, a parked pair drives `clk_p` = 1 with `oe_p` = 1, and has `oe_n` = 0.
- R5: With `tri_mode` = 1, a parked pair has `oe_p` = 0 and `oe_n` = 0.
- R6: `pll_en` falls at least one reference cycle after every pair has `oe_n` = 0. Whenever `pll_en` is 0, all `oe_n` are 0.
- R7: After the request returns high, `pll_en` rises and the pairs stay parked until `pll_lock` is seen. Output then restarts in a low phase of the true clock, and the first high pulse on `clk_p` lasts exactly half a forwarded-clock period.
- R8: If `pll_lock` does not arrive within `LOCK_CYC` reference cycles of entering the lock wait, `lock_timeout` goes to 1. It returns to 0 when lock arrives.
- R9: With `tri_mode` = 1, if the lock wait lasts `DRIVE_CYC` reference cycles, the parked pairs switch to the driven pattern of R4 until output restarts.
- R10: A pair whose `out_en` bit is 0 shows the parked pattern, even while the other pairs are running.
- R11: While running, an enabled pair has `oe_p` = `oe_n` = 1, `clk_p` follows the forwarded clock, and `clk_n` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that samples all inputs |
| rst | input | 1 | Synchronous active-high power-up reset; leaves the block powered down |
| pwr_req_n | input | 1 | Asynchronous active-low power-down request |
| fwd_clk | input | 1 | Forwarded clock to be distributed, sampled by `clk` |
| pll_lock | input | 1 | Lock indication from the PLL |
| tri_mode | input | 1 | Parked pattern select: 0 true high / complement tri-stated, 1 both tri-stated |
| out_en | input | N_OUT | Per-pair enable; 0 holds that pair parked |
| clk_p | output | N_OUT | True clock output level per pair |
| clk_n | output | N_OUT | Complement clock output level per pair |
| oe_p | output | N_OUT | Output enable of the true output per pair |
| oe_n | output | N_OUT | Output enable of the complement output per pair |
| pll_en | output | 1 | PLL enable |
| lock_timeout | output | 1 | Lock did not arrive within `LOCK_CYC` cycles |

## Verification
The hardest situation to reach from the ports is a lock wait that runs past both the drive window and the timeout. A normal PLL locks long before either limit. The bench therefore includes a lock model that can be held off. It powers down in tri-state mode, releases the request with lock held, and samples the pairs before the drive window ends, after it ends, and after the timeout. The two-edge qualification is reached by a request pulse of three reference cycles. Such a pulse can overlap only one complement rising edge at an eight-cycle forwarded period.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_LOCKWAIT,
        ST_ALIGN,
        ST_RUN,
        ST_ARMED,
        ST_PARK
    } pd_state_e;

    typedef struct packed {
        logic p;
        logic n;
        logic oe_p;
        logic oe_n;
    } diff_pair_t;

    localparam int QUAL_EDGES = 2;

    function automatic diff_pair_t parked_pair(input logic tri_sel);
        diff_pair_t r;
        if (tri_sel) begin
            r = '{p: 1'b0, n: 1'b0, oe_p: 1'b0, oe_n: 1'b0};
        end else begin
            r = '{p: 1'b1, n: 1'b0, oe_p: 1'b1, oe_n: 1'b0};
        end
        return r;
    endfunction

    function automatic diff_pair_t live_pair(input logic phase);
        diff_pair_t r;
        r = '{p: phase, n: ~phase, oe_p: 1'b1, oe_n: 1'b1};
        return r;
    endfunction

endpackage

// File: rtl/clkpd_req_sync.sv
module clkpd_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n_async,
    output logic req_n_sync
);
    logic [STAGES-1:0] chain;

    // Reset value 0 means "power-down requested", so power-up reset parks. R1
    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], req_n_async};
        end
    end

    assign req_n_sync = chain[STAGES-1];
endmodule

// File: rtl/clkpd_qualifier.sv
module clkpd_qualifier
    import clkpd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic fwd_clk,
    input  logic req_n_s,
    output logic fwd_ph,
    output logic comp_fall,
    output logic qualified
);
    localparam int CW = $clog2(QUAL_EDGES + 1);

    logic         ph_q, ph_d;
    logic         comp_rise;
    logic [CW-1:0] edge_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= 1'b0;
            ph_d <= 1'b0;
        end else begin
            ph_q <= fwd_clk;
            ph_d <= ph_q;
        end
    end

    // Complement rises when the true phase falls, and vice versa.
    assign comp_rise = ph_d & ~ph_q;
    assign comp_fall = ~ph_d & ph_q;
    assign fwd_ph    = ph_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            edge_cnt <= '0;
        end else if (comp_rise) begin
            if (!req_n_s) begin
                if (edge_cnt != CW'(QUAL_EDGES)) edge_cnt <= edge_cnt + 1'b1;
            end else begin
                edge_cnt <= '0;
            end
        end
    end

    assign qualified = (edge_cnt == CW'(QUAL_EDGES));

    AST_QUAL_NEEDS_LOW_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(qualified) |-> !$past(req_n_s)); // R3
endmodule

// File: rtl/clkpd_fsm.sv
module clkpd_fsm
    import clkpd_pkg::*;
#(
    parameter int LOCK_CYC  = 50000,
    parameter int DRIVE_CYC = 15000
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n_s,
    input  logic pll_lock,
    input  logic fwd_ph,
    input  logic comp_fall,
    input  logic qualified,
    output logic pll_en,
    output logic lock_timeout,
    output logic run_gate,
    output logic drive_force,
    output logic qual_clear
);
    localparam int TW = $clog2(LOCK_CYC + 1);

    pd_state_e     state, state_nx;
    logic [TW-1:0] timer;
    logic          waiting;

    always_comb begin
        state_nx = state;
        case (state)
            ST_OFF:      if (req_n_s) state_nx = ST_LOCKWAIT;
            ST_LOCKWAIT: if (!req_n_s) state_nx = ST_OFF;
                         else if (pll_lock) state_nx = ST_ALIGN;
            ST_ALIGN:    if (!req_n_s) state_nx = ST_OFF;
                         else if (!pll_lock) state_nx = ST_LOCKWAIT;
                         else if (!fwd_ph) state_nx = ST_RUN;
            ST_RUN:      if (qualified) state_nx = ST_ARMED;
            ST_ARMED:    if (comp_fall) state_nx = ST_PARK;
            ST_PARK:     state_nx = ST_OFF;
            default:     state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= state_nx;
    end

    assign waiting = (state == ST_LOCKWAIT) || (state == ST_ALIGN);

    always_ff @(posedge clk) begin
        if (rst || !waiting) begin
            timer <= '0;
        end else if (timer != TW'(LOCK_CYC)) begin
            timer <= timer + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_timeout <= 1'b0;
        end else if (pll_lock) begin
            lock_timeout <= 1'b0;
        end else if (state == ST_LOCKWAIT && timer >= TW'(LOCK_CYC)) begin
            lock_timeout <= 1'b1;
        end
    end

    // Pairs run in RUN, keep running in ARMED up to the park edge,
    // and start from ALIGN on the same edge that enters RUN.
    assign run_gate = (state == ST_RUN)
                    || (state == ST_ARMED && !comp_fall)
                    || (state == ST_ALIGN && req_n_s && pll_lock && !fwd_ph);

    assign drive_force = waiting && (timer >= TW'(DRIVE_CYC));
    assign qual_clear  = !((state == ST_RUN) || (state == ST_ARMED));
    assign pll_en      = (state != ST_OFF);

    AST_ARM_AFTER_QUAL: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && $past(state) == ST_RUN) |-> $past(qualified)); // R3
    AST_RUN_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && $past(state) == ST_ALIGN) |-> $past(pll_lock)); // R7
    AST_TIMEOUT_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_timeout) |-> !$past(pll_lock)); // R8
endmodule

// File: rtl/clkpd_pair.sv
module clkpd_pair
    import clkpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       run_gate,
    input  logic       tri_sel,
    input  logic       drive_force,
    input  logic       fwd_ph,
    output diff_pair_t pair_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= parked_pair(tri_sel);
        end else if (run_gate && en) begin
            pair_q <= live_pair(fwd_ph);
        end else begin
            pair_q <= parked_pair(tri_sel & ~drive_force);
        end
    end

    AST_DISABLED_PARKED: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pair_q.oe_n); // R10
endmodule

// File: rtl/clkout_pd_seq.sv
module clkout_pd_seq
    import clkpd_pkg::*;
#(
    parameter int N_OUT     = 4,
    parameter int LOCK_CYC  = 50000,
    parameter int DRIVE_CYC = 15000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_req_n,
    input  logic             fwd_clk,
    input  logic             pll_lock,
    input  logic             tri_mode,
    input  logic [N_OUT-1:0] out_en,
    output logic [N_OUT-1:0] clk_p,
    output logic [N_OUT-1:0] clk_n,
    output logic [N_OUT-1:0] oe_p,
    output logic [N_OUT-1:0] oe_n,
    output logic             pll_en,
    output logic             lock_timeout
);
    logic req_n_s, fwd_ph, comp_fall, qualified;
    logic run_gate, drive_force, qual_clear;

    clkpd_req_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .req_n_async(pwr_req_n), .req_n_sync(req_n_s)
    );

    clkpd_qualifier u_qual (
        .clk(clk), .rst(rst), .clear(qual_clear), .fwd_clk(fwd_clk),
        .req_n_s(req_n_s), .fwd_ph(fwd_ph), .comp_fall(comp_fall),
        .qualified(qualified)
    );

    clkpd_fsm #(.LOCK_CYC(LOCK_CYC), .DRIVE_CYC(DRIVE_CYC)) u_fsm (
        .clk(clk), .rst(rst), .req_n_s(req_n_s), .pll_lock(pll_lock),
        .fwd_ph(fwd_ph), .comp_fall(comp_fall), .qualified(qualified),
        .pll_en(pll_en), .lock_timeout(lock_timeout), .run_gate(run_gate),
        .drive_force(drive_force), .qual_clear(qual_clear)
    );

    generate
        for (genvar g = 0; g < N_OUT; g++) begin : g_pair
            diff_pair_t pq;
            clkpd_pair u_pair (
                .clk(clk), .rst(rst), .en(out_en[g]), .run_gate(run_gate),
                .tri_sel(tri_mode), .drive_force(drive_force),
                .fwd_ph(fwd_ph), .pair_q(pq)
            );
            assign clk_p[g] = pq.p;
            assign clk_n[g] = pq.n;
            assign oe_p[g]  = pq.oe_p;
            assign oe_n[g]  = pq.oe_n;
        end
    endgenerate

    AST_PLL_OFF_PARKED: assert property (@(posedge clk) disable iff (rst)
        !pll_en |-> (oe_n == '0)); // R6
    AST_PARK_BEFORE_PLL_OFF: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_en) |-> ($past(oe_n) == '0)); // R6
    AST_TRI_PARK: assert property (@(posedge clk) disable iff (rst)
        (!pll_en && !$past(pll_en) && tri_mode && $past(tri_mode))
        |-> (oe_p == '0 && oe_n == '0)); // R5
    AST_DRIVE_PARK: assert property (@(posedge clk) disable iff (rst)
        (!pll_en && !$past(pll_en) && !tri_mode && !$past(tri_mode))
        |-> (oe_p == '1 && clk_p == '1)); // R4
endmodule

// File: tb/clkout_pd_seq_tb.sv
module clkout_pd_seq_tb;
    localparam int N    = 4;
    localparam int LK   = 200;
    localparam int DR   = 60;
    localparam int HALF = 4;

    logic clk = 1'b0, rst = 1'b1, req_n = 1'b1, fwd = 1'b0, lock = 1'b0;
    logic tri_m = 1'b0, lock_hold = 1'b0, mon_on = 1'b0;
    logic [N-1:0] en = '1;
    logic [N-1:0] clk_p, clk_n, oe_p, oe_n;
    logic pll_en, lock_timeout;

    int errors = 0, checks = 0;
    int ph = 0, lk_cnt = 0, hi_w = 0;

    clkout_pd_seq #(.N_OUT(N), .LOCK_CYC(LK), .DRIVE_CYC(DR)) u_dut (
        .clk(clk), .rst(rst), .pwr_req_n(req_n), .fwd_clk(fwd),
        .pll_lock(lock), .tri_mode(tri_m), .out_en(en),
        .clk_p(clk_p), .clk_n(clk_n), .oe_p(oe_p), .oe_n(oe_n),
        .pll_en(pll_en), .lock_timeout(lock_timeout)
    );

    always #10 clk = ~clk;

    // Forwarded clock: period 2*HALF reference cycles, changed away from posedge.
    always @(negedge clk) begin
        if (ph == HALF - 1) begin
            ph  <= 0;
            fwd <= ~fwd;
        end else begin
            ph <= ph + 1;
        end
    end

    // PLL model: locks 20 cycles after enable unless held off.
    always @(posedge clk) begin
        if (!pll_en) begin
            lk_cnt <= 0;
            lock   <= 1'b0;
        end else begin
            if (lk_cnt < 1000) lk_cnt <= lk_cnt + 1;
            lock <= (lk_cnt >= 20) && !lock_hold;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Glitch monitor on pair 0 true output (R3, R7)
    always @(negedge clk) begin
        if (mon_on && oe_p[0]) begin
            if (clk_p[0]) begin
                hi_w = hi_w + 1;
            end else begin
                if (hi_w > 0) chk(hi_w >= HALF, "R3 short high pulse", hi_w, HALF);
                hi_w = 0;
            end
        end else begin
            hi_w = 0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    typedef struct packed {
        logic       m;
        logic [3:0] e;
        logic       r;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{m: 1'b0, e: 4'b1111, r: 1'b1},
        '{m: 1'b0, e: 4'b1010, r: 1'b1},
        '{m: 1'b1, e: 4'b0110, r: 1'b1},
        '{m: 1'b0, e: 4'b1111, r: 1'b0},
        '{m: 1'b1, e: 4'b1111, r: 1'b0},
        '{m: 1'b1, e: 4'b1111, r: 1'b1},
        '{m: 1'b0, e: 4'b0000, r: 1'b1}
    };

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(pll_en == 1'b0, "R1 pll_en", pll_en, 0);
        chk(oe_n == '0, "R1 oe_n", oe_n, 0);
        chk(lock_timeout == 1'b0, "R1 lock_timeout", lock_timeout, 0);
        chk(clk_p == '1 && oe_p == '1, "R1 parked mode0", clk_p, 4'hf);
        rst = 1'b0;
        repeat (100) @(negedge clk);

        // R2: a three-cycle low pulse covers at most one complement rise
        req_n = 1'b0;
        repeat (3) @(negedge clk);
        req_n = 1'b1;
        repeat (60) @(negedge clk);
        chk(pll_en == 1'b1, "R2 pll_en kept", pll_en, 1);
        chk(oe_n == '1, "R2 outputs kept running", oe_n, 4'hf);

        // Table walk: R4, R5, R7, R10, R11
        for (int k = 0; k < 7; k++) begin
            tri_m = VEC[k].m;
            en    = VEC[k].e;
            req_n = VEC[k].r;
            repeat (120) @(negedge clk);
            chk(pll_en == VEC[k].r, "R7 pll_en follows request", pll_en, VEC[k].r);
            for (int i = 0; i < N; i++) begin
                if (VEC[k].r && VEC[k].e[i]) begin
                    bit seen0 = 0, seen1 = 0, comp_ok = 1;
                    for (int s = 0; s < 16; s++) begin
                        @(negedge clk);
                        if (clk_p[i]) seen1 = 1; else seen0 = 1;
                        if (clk_n[i] != ~clk_p[i] || !oe_p[i] || !oe_n[i]) comp_ok = 0;
                    end
                    chk(seen0 && seen1 && comp_ok, "R11 running pair", {seen0, seen1, comp_ok}, 3'b111);
                end else if (VEC[k].m) begin
                    chk(!oe_p[i] && !oe_n[i],
                        VEC[k].r ? "R10 disabled pair tri" : "R5 tri park",
                        {oe_p[i], oe_n[i]}, 0);
                end else begin
                    chk(clk_p[i] && oe_p[i] && !oe_n[i],
                        VEC[k].r ? "R10 disabled pair driven" : "R4 driven park",
                        {clk_p[i], oe_p[i], oe_n[i]}, 3'b110);
                end
            end
        end

        // R3, R6: ordered power-down with glitch monitor
        tri_m = 1'b0;
        en    = '1;
        req_n = 1'b1;
        repeat (120) @(negedge clk);
        mon_on = 1'b1;
        begin
            int falls = 0, guard = 0;
            logic prev_fwd, prev_oe;
            prev_fwd = fwd;
            prev_oe  = |oe_n;
            req_n = 1'b0;
            while (pll_en && guard < 300) begin
                @(negedge clk);
                guard++;
                if (prev_fwd && !fwd) falls++;
                prev_fwd = fwd;
                if (pll_en) prev_oe = |oe_n;
            end
            chk(!prev_oe, "R6 parked before pll_en fell", prev_oe, 0);
            chk(falls >= 2, "R3 two complement rises before park", falls, 2);
            chk(clk_p == '1 && oe_n == '0, "R3 parked on true rise", clk_p, 4'hf);
        end

        // R7: restart after lock, full first pulse
        req_n = 1'b1;
        begin
            int guard = 0, w = 0;
            while (!lock && guard < 300) begin
                @(negedge clk);
                guard++;
                if (!lock) chk(oe_n == '0, "R7 held until lock", oe_n, 0);
            end
            while (!oe_n[0] && guard < 400) begin @(negedge clk); guard++; end
            chk(clk_p[0] == 1'b0, "R7 restart in low phase", clk_p[0], 0);
            while (!clk_p[0] && guard < 500) begin @(negedge clk); guard++; end
            while (clk_p[0] && guard < 600) begin @(negedge clk); guard++; w++; end
            chk(w == HALF, "R7 first pulse full width", w, HALF);
        end
        mon_on = 1'b0;

        // R8, R9: lock held off in tri-state mode
        tri_m = 1'b1;
        req_n = 1'b0;
        begin
            int guard = 0;
            while (pll_en && guard < 300) begin @(negedge clk); guard++; end
        end
        lock_hold = 1'b1;
        repeat (5) @(negedge clk);
        req_n = 1'b1;
        repeat (30) @(negedge clk);
        chk(oe_p == '0 && oe_n == '0, "R9 still tri inside window", oe_p, 0);
        chk(lock_timeout == 1'b0, "R8 no early timeout", lock_timeout, 0);
        repeat (50) @(negedge clk);
        chk(oe_p == '1 && clk_p == '1 && oe_n == '0, "R9 driven after window", {oe_p, clk_p}, 8'hff);
        repeat (LK) @(negedge clk);
        chk(lock_timeout == 1'b1, "R8 timeout raised", lock_timeout, 1);
        lock_hold = 1'b0;
        repeat (60) @(negedge clk);
        chk(lock_timeout == 1'b0, "R8 timeout cleared by lock", lock_timeout, 0);
        chk(oe_n == '1 && oe_p == '1, "R11 resumed after late lock", {oe_p, oe_n}, 8'hff);

        finish_run();
    end
endmodule